// File: doc/BRIEF.md
# Vector Pipeline Latency Tracker

This block tracks the timing of vector operations through two execution paths, carrying only a valid bit and a destination tag per operation. The floating-point path is fully pipelined and accepts one operation per cycle. It presents the operation's tag for result forwarding in the fourth execute cycle. Completion eligibility for that tag is signalled on one of two ports. An operation that entered with the compatibility mode clear becomes eligible in the same cycle it forwards. An operation that entered with the mode set becomes eligible one cycle later.

The simple-integer path finishes an ordinary operation one cycle after acceptance. A serializing operation, such as a move to or from the vector status register, is parked in a holding slot. It issues only after an external input reports that it is the oldest uncompleted instruction. While the slot is occupied, the integer path stops accepting work. A flush input discards everything in flight in both paths.

Top module: `vec_lat_tracker`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every valid output is 0 and `int_ready` is 1.
- R2: A floating-point operation sampled at clock edge N appears on `fwd_valid`/`fwd_tag` after edge N+3, in its fourth execute cycle. Back-to-back operations each appear, one per cycle, in entry order.
- R3: An operation that entered with `compat_mode`=0 raises `cpl_valid` with its tag in the same cycle as its forwarding, and never raises `cplx_valid`.
- R4: An operation that entered with `compat_mode`=1 forwards at the same point as in R2. It raises `cplx_valid` with its tag one cycle after forwarding, and never raises `cpl_valid`.
- R5: `compat_mode` is sampled only when an operation enters, so changing it while operations are in flight does not alter their completion timing. `cpl_valid` and `cplx_valid` may be high in the same cycle for different tags.
- R6: A non-serializing integer operation (`int_serial`=0) accepted at edge N raises `int_done_valid` with its tag after edge N.
- R7: A serializing integer operation (`int_serial`=1) drops `int_ready` after its acceptance edge. It produces no `int_done_valid` until `oldest`=1 is sampled at some edge M, and it completes after edge M with `int_ready` back at 1.
- R8: An integer operation presented while `int_ready`=0 is ignored and never produces `int_done_valid`.
- R9: `flush`=1 sampled at an edge clears every in-flight stage and the holding slot. An operation presented in that same cycle is not accepted. After that edge all valid outputs are 0 and `int_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all in-flight operations |
| compat_mode | input | 1 | Adds one completion cycle to entering floating-point operations |
| fp_valid | input | 1 | Floating-point operation enters this cycle |
| fp_tag | input | 4 | Destination tag of the entering floating-point operation |
| int_valid | input | 1 | Integer operation offered this cycle |
| int_serial | input | 1 | Offered integer operation is serializing |
| int_tag | input | 4 | Destination tag of the offered integer operation |
| oldest | input | 1 | Held serializing operation is the oldest uncompleted instruction |
| int_ready | output | 1 | Integer path accepts an operation this cycle |
| fwd_valid | output | 1 | A floating-point result is forwardable this cycle |
| fwd_tag | output | 4 | Tag of the forwardable result |
| cpl_valid | output | 1 | Completion eligibility, standard-latency operation |
| cpl_tag | output | 4 | Tag for `cpl_valid` |
| cplx_valid | output | 1 | Completion eligibility, extended-latency operation |
| cplx_tag | output | 4 | Tag for `cplx_valid` |
| int_done_valid | output | 1 | Integer operation completes this cycle |
| int_done_tag | output | 4 | Tag of the completing integer operation |

## Verification
A stage register that loses or duplicates an entry shows up on `fwd_valid` at the expected fourth-cycle slot, so such a fault is visible within four cycles of entry. A mode bit that is not carried with its operation moves its completion to the wrong port, or shifts it by one cycle, when that operation retires. A holding slot that releases early gives an `int_done_valid` before `oldest` is raised, and a lost holding slot leaves `int_ready` low or drops a completion. Both are visible on the cycle after the fault. A flush that misses a stage lets a stale tag reach an output within five cycles.

// File: rtl/vlt_pkg.sv
package vlt_pkg;

    parameter int unsigned VLT_TAG_W = 4;

    typedef logic [VLT_TAG_W-1:0] vlt_tag_t;

    // One in-flight floating-point operation: valid, entry-time mode, tag.
    typedef struct packed {
        logic     vld;
        logic     ext;
        vlt_tag_t tag;
    } vlt_slot_t;

    localparam vlt_slot_t VLT_EMPTY = '{vld: 1'b0, ext: 1'b0, tag: '0};

    function automatic vlt_slot_t vlt_make(input logic v, input logic e, input vlt_tag_t t);
        vlt_slot_t s;
        s.vld = v;
        s.ext = v & e;
        s.tag = t;
        return s;
    endfunction

endpackage

// File: rtl/vfp_pipe.sv
module vfp_pipe
    import vlt_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      flush,
    input  logic      in_vld,
    input  logic      in_ext,
    input  vlt_tag_t  in_tag,
    output vlt_slot_t fwd_slot,
    output vlt_slot_t late_slot
);
    localparam int unsigned LAST = DEPTH - 1;

    vlt_slot_t stage [DEPTH];
    vlt_slot_t tail;

    always_ff @(posedge clk) begin
        if (rst || flush) stage[0] <= VLT_EMPTY;
        else              stage[0] <= vlt_make(in_vld, in_ext, in_tag);
    end

    generate
        for (genvar g = 1; g < DEPTH; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst || flush) stage[g] <= VLT_EMPTY;
                else              stage[g] <= stage[g-1];
            end
        end
    endgenerate

    // Extra completion stage, populated only by extended-mode entries.
    always_ff @(posedge clk) begin
        if (rst || flush) tail <= VLT_EMPTY;
        else              tail <= vlt_make(stage[LAST].vld & stage[LAST].ext, 1'b1, stage[LAST].tag);
    end

    assign fwd_slot  = stage[LAST];
    assign late_slot = tail;

endmodule

// File: rtl/vsi_path.sv
module vsi_path
    import vlt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     flush,
    input  logic     in_vld,
    input  logic     in_serial,
    input  vlt_tag_t in_tag,
    input  logic     oldest,
    output logic     ready,
    output logic     done_vld,
    output vlt_tag_t done_tag
);
    logic     park_vld;
    vlt_tag_t park_tag;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            park_vld <= 1'b0;
            park_tag <= '0;
            done_vld <= 1'b0;
            done_tag <= '0;
        end else begin
            done_vld <= 1'b0;
            if (park_vld) begin
                if (oldest) begin
                    done_vld <= 1'b1;
                    done_tag <= park_tag;
                    park_vld <= 1'b0;
                end
            end else if (in_vld) begin
                if (in_serial) begin
                    park_vld <= 1'b1;
                    park_tag <= in_tag;
                end else begin
                    done_vld <= 1'b1;
                    done_tag <= in_tag;
                end
            end
        end
    end

    assign ready = ~park_vld;

endmodule

// File: rtl/vec_lat_tracker.sv
module vec_lat_tracker
    import vlt_pkg::*;
#(
    parameter int unsigned FWD_STAGES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  logic                 compat_mode,
    input  logic                 fp_valid,
    input  logic [VLT_TAG_W-1:0] fp_tag,
    input  logic                 int_valid,
    input  logic                 int_serial,
    input  logic [VLT_TAG_W-1:0] int_tag,
    input  logic                 oldest,
    output logic                 int_ready,
    output logic                 fwd_valid,
    output logic [VLT_TAG_W-1:0] fwd_tag,
    output logic                 cpl_valid,
    output logic [VLT_TAG_W-1:0] cpl_tag,
    output logic                 cplx_valid,
    output logic [VLT_TAG_W-1:0] cplx_tag,
    output logic                 int_done_valid,
    output logic [VLT_TAG_W-1:0] int_done_tag
);
    vlt_slot_t fwd_s;
    vlt_slot_t late_s;

    vfp_pipe #(.DEPTH(FWD_STAGES)) i_fp (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .in_vld   (fp_valid),
        .in_ext   (compat_mode),
        .in_tag   (fp_tag),
        .fwd_slot (fwd_s),
        .late_slot(late_s)
    );

    vsi_path i_int (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .in_vld   (int_valid),
        .in_serial(int_serial),
        .in_tag   (int_tag),
        .oldest   (oldest),
        .ready    (int_ready),
        .done_vld (int_done_valid),
        .done_tag (int_done_tag)
    );

    assign fwd_valid  = fwd_s.vld;
    assign fwd_tag    = fwd_s.tag;
    assign cpl_valid  = fwd_s.vld & ~fwd_s.ext;
    assign cpl_tag    = fwd_s.tag;
    assign cplx_valid = late_s.vld;
    assign cplx_tag   = late_s.tag;

endmodule

// File: rtl/vlt_checker.sv
module vlt_checker (
    input logic       clk,
    input logic       rst,
    input logic       flush,
    input logic       int_valid,
    input logic       int_serial,
    input logic       oldest,
    input logic       int_ready,
    input logic       fwd_valid,
    input logic [3:0] fwd_tag,
    input logic       cpl_valid,
    input logic [3:0] cpl_tag,
    input logic       cplx_valid,
    input logic [3:0] cplx_tag,
    input logic       int_done_valid
);
    assert_cpl_with_fwd_R3: assert property (@(posedge clk) disable iff (rst)
        cpl_valid |-> (fwd_valid && cpl_tag == fwd_tag));

    assert_cplx_trails_fwd_R4: assert property (@(posedge clk) disable iff (rst)
        cplx_valid |-> ($past(fwd_valid) && !$past(cpl_valid) && cplx_tag == $past(fwd_tag)));

    assert_plain_int_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        (int_done_valid && $past(int_ready)) |-> $past(int_valid && !int_serial));

    assert_serial_needs_oldest_R7: assert property (@(posedge clk) disable iff (rst)
        (int_done_valid && !$past(int_ready)) |-> $past(oldest));

    assert_serial_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        (!int_ready && !oldest && !flush) |=> (!int_done_valid && !int_ready));

    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (rst)
        $past(flush) |-> (!fwd_valid && !cpl_valid && !cplx_valid && !int_done_valid && int_ready));
endmodule

bind vec_lat_tracker vlt_checker i_vlt_checker (
    .clk           (clk),
    .rst           (rst),
    .flush         (flush),
    .int_valid     (int_valid),
    .int_serial    (int_serial),
    .oldest        (oldest),
    .int_ready     (int_ready),
    .fwd_valid     (fwd_valid),
    .fwd_tag       (fwd_tag),
    .cpl_valid     (cpl_valid),
    .cpl_tag       (cpl_tag),
    .cplx_valid    (cplx_valid),
    .cplx_tag      (cplx_tag),
    .int_done_valid(int_done_valid)
);

// File: tb/test_vec_lat_tracker.sv
`timescale 1ns/1ps
module test_vec_lat_tracker;

    typedef struct {
        int         cyc;
        logic [3:0] tag;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       flush = 1'b0;
    logic       compat_mode = 1'b0;
    logic       fp_valid = 1'b0;
    logic [3:0] fp_tag = '0;
    logic       int_valid = 1'b0;
    logic       int_serial = 1'b0;
    logic [3:0] int_tag = '0;
    logic       oldest = 1'b0;
    logic       int_ready;
    logic       fwd_valid, cpl_valid, cplx_valid, int_done_valid;
    logic [3:0] fwd_tag, cpl_tag, cplx_tag, int_done_tag;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   running = 1'b0;
    bit   finished = 1'b0;
    exp_t q_fwd[$];
    exp_t q_cpl[$];
    exp_t q_cplx[$];
    exp_t q_int[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    vec_lat_tracker i_vec_lat_tracker (
        .clk(clk), .rst(rst), .flush(flush), .compat_mode(compat_mode),
        .fp_valid(fp_valid), .fp_tag(fp_tag),
        .int_valid(int_valid), .int_serial(int_serial), .int_tag(int_tag),
        .oldest(oldest), .int_ready(int_ready),
        .fwd_valid(fwd_valid), .fwd_tag(fwd_tag),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag),
        .cplx_valid(cplx_valid), .cplx_tag(cplx_tag),
        .int_done_valid(int_done_valid), .int_done_tag(int_done_tag)
    );

    task automatic check_bit(input string req, input string nm, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, nm, cyc, act, exp);
        end
    endtask

    // Monitor side of the scoreboard: one port, one queue.
    task automatic watch(ref exp_t q[$], input logic v, input logic [3:0] t, input string nm);
        while (q.size() > 0 && q[0].cyc < cyc) begin
            n_chk++; n_bad++;
            $display("FAIL %s %s missed at cycle %0d: actual valid 0 expected tag %0h",
                     q[0].req, nm, q[0].cyc, q[0].tag);
            void'(q.pop_front());
        end
        if (q.size() > 0 && q[0].cyc == cyc) begin
            n_chk++;
            if (v !== 1'b1 || t !== q[0].tag) begin
                n_bad++;
                $display("FAIL %s %s at cycle %0d: actual valid %b tag %0h expected valid 1 tag %0h",
                         q[0].req, nm, cyc, v, t, q[0].tag);
            end
            void'(q.pop_front());
        end else if (v === 1'b1) begin
            n_chk++; n_bad++;
            $display("FAIL R3,R4,R8,R9 %s unexpected at cycle %0d: actual tag %0h expected valid 0",
                     nm, cyc, t);
        end
    endtask

    always @(negedge clk) begin
        if (running) begin
            watch(q_fwd,  fwd_valid,      fwd_tag,      "fwd");
            watch(q_cpl,  cpl_valid,      cpl_tag,      "cpl");
            watch(q_cplx, cplx_valid,     cplx_tag,     "cplx");
            watch(q_int,  int_done_valid, int_done_tag, "int_done");
        end
    end

    function automatic exp_t mk(input int c, input logic [3:0] t, input string r);
        exp_t e;
        e.cyc = c; e.tag = t; e.req = r;
        return e;
    endfunction

    task automatic trim(ref exp_t q[$], input int lim);
        for (int i = q.size() - 1; i >= 0; i--)
            if (q[i].cyc > lim) q.delete(i);
    endtask

    // Driver tasks: called at a falling edge, they hold inputs for one cycle.
    task automatic fp_op(input logic [3:0] t, input logic m);
        fp_valid = 1'b1; fp_tag = t; compat_mode = m;
        q_fwd.push_back(mk(cyc + 4, t, "R2"));
        if (m) q_cplx.push_back(mk(cyc + 5, t, "R4"));
        else   q_cpl.push_back(mk(cyc + 4, t, "R3"));
        @(negedge clk);
        fp_valid = 1'b0; compat_mode = ~m;
    endtask

    task automatic int_op(input logic [3:0] t, input logic s, input bit accepted);
        int_valid = 1'b1; int_serial = s; int_tag = t;
        if (accepted && !s) q_int.push_back(mk(cyc + 1, t, "R6"));
        @(negedge clk);
        int_valid = 1'b0; int_serial = 1'b0;
    endtask

    task automatic release_held(input logic [3:0] t);
        oldest = 1'b1;
        q_int.push_back(mk(cyc + 1, t, "R7"));
        @(negedge clk);
        oldest = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_flush(input logic [3:0] t);
        flush = 1'b1; fp_valid = 1'b1; fp_tag = t;
        trim(q_fwd, cyc); trim(q_cpl, cyc); trim(q_cplx, cyc); trim(q_int, cyc);
        @(negedge clk);
        flush = 1'b0; fp_valid = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check_bit("R1", "fwd_valid", fwd_valid, 1'b0);
        check_bit("R1", "cplx_valid", cplx_valid, 1'b0);
        check_bit("R1", "int_done_valid", int_done_valid, 1'b0);
        check_bit("R1", "int_ready", int_ready, 1'b1);
        rst = 1'b0;
        running = 1'b1;
        @(negedge clk);
        check_bit("R1", "cpl_valid", cpl_valid, 1'b0);

        // R2, R3: back-to-back standard operations
        fp_op(4'h1, 1'b0); fp_op(4'h2, 1'b0); fp_op(4'h3, 1'b0);
        idle(6);
        // R4: extended-mode operations
        fp_op(4'h4, 1'b1); fp_op(4'h5, 1'b1);
        idle(7);
        // R5: mode changes between entries; both completion ports fire together
        fp_op(4'h6, 1'b1); fp_op(4'h7, 1'b0); fp_op(4'h8, 1'b1);
        idle(7);

        // R6: plain integer operations
        int_op(4'h9, 1'b0, 1); int_op(4'hA, 1'b0, 1);
        idle(2);

        // R7, R8: serializing operation held until oldest
        int_op(4'hB, 1'b1, 1);
        check_bit("R7", "int_ready", int_ready, 1'b0);
        idle(2);
        int_op(4'hC, 1'b0, 0);       // R8: dropped while held
        idle(2);
        check_bit("R8", "int_ready", int_ready, 1'b0);
        release_held(4'hB);
        check_bit("R7", "int_ready", int_ready, 1'b1);
        idle(3);

        // R9: flush with work in both paths
        fp_op(4'hD, 1'b1); fp_op(4'hE, 1'b0);
        int_op(4'hF, 1'b1, 1);
        do_flush(4'h2);
        check_bit("R9", "int_ready", int_ready, 1'b1);
        check_bit("R9", "fwd_valid", fwd_valid, 1'b0);
        idle(7);
        fp_op(4'h3, 1'b0);
        int_op(4'h4, 1'b0, 1);
        idle(8);

        running = 1'b0;
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not end");
            summary();
            $finish;
        end
    end

endmodule